// File: doc/BRIEF.md
# Daisy-Chain Readback Sequencer

This block is an SPI master for a string of five devices that each take a 24-bit command. All devices share the serial clock and the chip select. Each device's data output feeds the data input of the next one, and the last device drives the master's MISO. One chip-select window therefore carries one 120-bit frame, with one 24-bit slot for each device.

The devices cannot return their data in a single chained frame. To read one device, the block first sends a request frame. That frame holds the read word in the target device's slot and the no-operation word in every other slot. The block then sends a frame made only of no-operation words and captures MISO during it. The reply sits in the target's slot of the captured frame.

A host starts a run with a pulse on `start`. The run takes a device mask and, optionally, a full write frame that is sent first. The block walks the selected devices from the lowest index up. It returns one 24-bit word with its device index and a valid strobe for each selected device, then pulses `done`. The host can repeat the run once for each device channel.

Top module: `daisy_readback_seq`

## Requirements
- R1: While reset is applied and after it is released, `cs_n` is high and `sclk`, `busy`, `done` and `rd_valid` are low, until a start is accepted.
- R2: Each chip-select window carries exactly N_DEV*24 (120) SCLK rising edges. SCLK is low whenever `cs_n` is high. MOSI changes only while SCLK falls, and MISO is sampled as SCLK rises (SPI mode 0). Words are sent most significant bit first.
- R3: When `do_write` is set at start, the first frame is `wr_frame` sent from its top bit down. The slot at bits [24*i+23:24*i] is meant for device i, where device 0 is nearest the master, so the slot for device N_DEV-1 is shifted first.
- R4: The request frame for device k holds 0x850000 in slot k and 0x00033C in every other slot.
- R5: The capture frame holds 0x00033C in every slot. The word reported for device k is the received frame's bits [24*k+23:24*k]. The first 24 bits received belong to the farthest device.
- R6: Selected devices are served in ascending index order, and unselected devices are skipped. Each selected device costs exactly one request frame followed by one capture frame, and yields one `rd_valid` pulse carrying `rd_index` = k.
- R7: The SCLK period is 2*`half_div` system clocks. A `half_div` of 0 acts as 1. The value is taken at the start of each frame.
- R8: `cs_n` stays high for at least GAP_CYC (4) system clocks between frames and after reset.
- R9: `busy` rises the cycle after a start is accepted and falls in the cycle where `done` pulses for one cycle. A start that arrives while `busy` is high is ignored.
- R10: A start with an all-zero mask and `do_write` clear produces no frame and reports `done` with no `rd_valid`.
- R11: A start presented during the cycle in which `done` is high is accepted, and `busy` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, sampled when idle |
| do_write | input | 1 | Send `wr_frame` before the reads |
| dev_mask | input | N_DEV | Devices to read, bit i for device i |
| wr_frame | input | N_DEV*24 | Write slots, slot i for device i |
| half_div | input | DIV_W | SCLK half period in system clocks |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_valid | output | 1 | Readback word strobe |
| rd_index | output | IDX_W | Device index of the readback word |
| rd_data | output | 24 | Readback word |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Shared chip select, active low |
| mosi | output | 1 | Serial data to device 0 |
| miso | input | 1 | Serial data from the last device |

## Verification
The end of one run and the acceptance of the next can fall in the same cycle. The bench detects the `done` pulse and drives a new `start` with a different mask in that same cycle. It then requires `busy` to be high on the following cycle and the second run's frames and words to match the second mask. A start that arrives in the middle of a run is also provoked. It must leave the frame sequence and the results of the run already in progress untouched.

// File: rtl/daisy_seq_pkg.sv
package daisy_seq_pkg;
  localparam int CMD_W = 24;
  localparam logic [CMD_W-1:0] NOP_CMD  = 24'h00033C;
  localparam logic [CMD_W-1:0] READ_CMD = 24'h850000;

  typedef enum logic [1:0] {FK_WRITE, FK_READ, FK_NOP} frame_kind_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_WR_GO, SQ_WR_WAIT, SQ_PICK,
    SQ_RQ_GO, SQ_RQ_WAIT, SQ_CP_GO, SQ_CP_WAIT, SQ_FIN
  } seq_state_e;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} shift_state_e;
endpackage

// File: rtl/dr_frame_builder.sv
module dr_frame_builder import daisy_seq_pkg::*; #(
  parameter int N_DEV = 5,
  parameter int IDX_W = 3
) (
  input  frame_kind_e                 kind,
  input  logic [N_DEV*CMD_W-1:0]      wr_frame,
  input  logic [IDX_W-1:0]            target,
  output logic [N_DEV*CMD_W-1:0]      frame
);
  for (genvar s = 0; s < N_DEV; s++) begin : g_slot
    always_comb begin
      unique case (kind)
        FK_WRITE: frame[s*CMD_W +: CMD_W] = wr_frame[s*CMD_W +: CMD_W];
        FK_READ:  frame[s*CMD_W +: CMD_W] = (target == IDX_W'(s)) ? READ_CMD : NOP_CMD;
        default:  frame[s*CMD_W +: CMD_W] = NOP_CMD;
      endcase
    end
  end
endmodule

// File: rtl/dr_slot_pick.sv
module dr_slot_pick import daisy_seq_pkg::*; #(
  parameter int N_DEV = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_DEV-1:0]            pend,
  input  logic [N_DEV*CMD_W-1:0]      rx_frame,
  input  logic [IDX_W-1:0]            sel,
  output logic                        any_pend,
  output logic [IDX_W-1:0]            first_idx,
  output logic [CMD_W-1:0]            sel_word
);
  always_comb begin
    first_idx = '0;
    for (int i = N_DEV-1; i >= 0; i--) begin
      if (pend[i]) first_idx = IDX_W'(i);
    end
    any_pend = |pend;
  end

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (sel == IDX_W'(i)) sel_word = rx_frame[i*CMD_W +: CMD_W];
    end
  end
endmodule

// File: rtl/dr_spi_shifter.sv
module dr_spi_shifter import daisy_seq_pkg::*; #(
  parameter int FRAME_W = 120,
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [FRAME_W-1:0] tx_frame,
  input  logic [DIV_W-1:0]   half_div,
  input  logic               miso,
  output logic               ready,
  output logic               frame_done,
  output logic [FRAME_W-1:0] rx_frame,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi
);
  localparam int BC_W = $clog2(FRAME_W);
  localparam int GC_W = $clog2(GAP_CYC + 1);

  shift_state_e       st;
  logic [FRAME_W-1:0] sr;
  logic [BC_W-1:0]    bitcnt;
  logic [DIV_W-1:0]   ph;
  logic [DIV_W-1:0]   half_q;
  logic [GC_W-1:0]    gapcnt;

  assign ready = (st == SH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SH_GAP;
      gapcnt     <= '0;
      sr         <= '0;
      rx_frame   <= '0;
      bitcnt     <= '0;
      ph         <= '0;
      half_q     <= DIV_W'(1);
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      mosi       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (st)
        SH_IDLE: begin
          if (launch) begin
            cs_n   <= 1'b0;
            sr     <= tx_frame;
            mosi   <= tx_frame[FRAME_W-1];
            half_q <= (half_div == '0) ? DIV_W'(1) : half_div;
            ph     <= '0;
            bitcnt <= '0;
            sclk   <= 1'b0;
            st     <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (ph == half_q - 1'b1) begin
            ph <= '0;
            if (!sclk) begin
              sclk     <= 1'b1;
              rx_frame <= {rx_frame[FRAME_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bitcnt == BC_W'(FRAME_W-1)) begin
                cs_n       <= 1'b1;
                mosi       <= 1'b0;
                frame_done <= 1'b1;
                gapcnt     <= '0;
                st         <= SH_GAP;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                sr     <= {sr[FRAME_W-2:0], 1'b0};
                mosi   <= sr[FRAME_W-2];
              end
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: begin
          if (gapcnt == GC_W'(GAP_CYC-1)) st <= SH_IDLE;
          else gapcnt <= gapcnt + 1'b1;
        end
      endcase
    end
  end

  // Observation counters for the bus-level properties below
  logic            sclk_q;
  logic [BC_W:0]   rise_cnt;
  logic [GC_W:0]   hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
      hi_run   <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_n) hi_run <= '0;
      else if (hi_run < (GC_W+1)'(GAP_CYC)) hi_run <= hi_run + 1'b1;
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rise_cnt == (BC_W+1)'(FRAME_W)));
  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_run >= (GC_W+1)'(GAP_CYC)));
endmodule

// File: rtl/daisy_readback_seq.sv
module daisy_readback_seq import daisy_seq_pkg::*; #(
  parameter int N_DEV   = 5,
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4,
  localparam int IDX_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int FRAME_W = N_DEV * CMD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               do_write,
  input  logic [N_DEV-1:0]   dev_mask,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [DIV_W-1:0]   half_div,
  output logic               busy,
  output logic               done,
  output logic               rd_valid,
  output logic [IDX_W-1:0]   rd_index,
  output logic [CMD_W-1:0]   rd_data,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  seq_state_e         st;
  logic [N_DEV-1:0]   pend;
  logic [N_DEV-1:0]   req_q;
  logic [FRAME_W-1:0] wr_q;
  logic [IDX_W-1:0]   cur;

  frame_kind_e        kind;
  logic [FRAME_W-1:0] tx_frame;
  logic [FRAME_W-1:0] rx_frame;
  logic               sh_ready;
  logic               sh_done;
  logic               launch;
  logic               any_pend;
  logic [IDX_W-1:0]   first_idx;
  logic [CMD_W-1:0]   sel_word;

  always_comb begin
    unique case (st)
      SQ_WR_GO: kind = FK_WRITE;
      SQ_RQ_GO: kind = FK_READ;
      default:  kind = FK_NOP;
    endcase
    launch = sh_ready && (st == SQ_WR_GO || st == SQ_RQ_GO || st == SQ_CP_GO);
  end

  dr_frame_builder #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_build (
    .kind(kind), .wr_frame(wr_q), .target(cur), .frame(tx_frame)
  );

  dr_slot_pick #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .rx_frame(rx_frame), .sel(cur),
    .any_pend(any_pend), .first_idx(first_idx), .sel_word(sel_word)
  );

  dr_spi_shifter #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .GAP_CYC(GAP_CYC)) u_shift (
    .clk(clk), .rst(rst), .launch(launch), .tx_frame(tx_frame),
    .half_div(half_div), .miso(miso), .ready(sh_ready),
    .frame_done(sh_done), .rx_frame(rx_frame),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_index <= '0;
      rd_data  <= '0;
      pend     <= '0;
      req_q    <= '0;
      wr_q     <= '0;
      cur      <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      unique case (st)
        SQ_IDLE: if (start) begin
          busy  <= 1'b1;
          pend  <= dev_mask;
          req_q <= dev_mask;
          wr_q  <= wr_frame;
          st    <= do_write ? SQ_WR_GO : SQ_PICK;
        end
        SQ_WR_GO:   if (sh_ready) st <= SQ_WR_WAIT;
        SQ_WR_WAIT: if (sh_done)  st <= SQ_PICK;
        SQ_PICK: begin
          if (any_pend) begin
            cur <= first_idx;
            st  <= SQ_RQ_GO;
          end else begin
            st <= SQ_FIN;
          end
        end
        SQ_RQ_GO:   if (sh_ready) st <= SQ_RQ_WAIT;
        SQ_RQ_WAIT: if (sh_done)  st <= SQ_CP_GO;
        SQ_CP_GO:   if (sh_ready) st <= SQ_CP_WAIT;
        SQ_CP_WAIT: if (sh_done) begin
          rd_valid  <= 1'b1;
          rd_index  <= cur;
          rd_data   <= sel_word;
          pend[cur] <= 1'b0;
          st        <= SQ_PICK;
        end
        SQ_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_cs_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
  assert_valid_in_run_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (busy && req_q[rd_index]));
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/daisy_readback_seq_tb.sv
module daisy_readback_seq_tb;
  localparam int N = 5;
  localparam int W = 24;
  localparam int FW = N * W;
  localparam int GAP = 4;
  localparam logic [W-1:0] NOPW = 24'h00033C;
  localparam logic [W-1:0] RDW  = 24'h850000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          do_write = 1'b0;
  logic [N-1:0]  dev_mask = '0;
  logic [FW-1:0] wr_frame = '0;
  logic [7:0]    half_div = 8'd1;
  logic          busy, done, rd_valid, sclk, cs_n, mosi, miso;
  logic [2:0]    rd_index;
  logic [W-1:0]  rd_data;

  daisy_readback_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .do_write(do_write),
    .dev_mask(dev_mask), .wr_frame(wr_frame), .half_div(half_div),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_index(rd_index),
    .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0;
  int n_fail = 0;
  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Chain model: device 0 takes MOSI, device N-1 drives MISO
  logic [W-1:0] dsr [N];
  logic [W-1:0] dreg [N];
  bit           dpend [N];
  logic [W-1:0] exp_reg [N];
  assign miso = dsr[N-1][W-1];

  logic          sclk_q = 1'b0;
  logic          cs_q = 1'b1;
  logic [FW-1:0] mon;
  logic [FW-1:0] frm [16];
  int            flen [16];
  int            nfrm = 0, mbits = 0, nrise = 0, per = 0, min_gap = 1000;
  longint        cyc = 0, last_rise = 0, cs_up_t = 0;

  always @(negedge clk) begin
    logic [W-1:0] old [N];
    logic [W-1:0] cmd;
    cyc = cyc + 1;
    if (cs_q && (cs_n === 1'b0)) begin
      for (int d = 0; d < N; d++) if (dpend[d]) begin dsr[d] = dreg[d]; dpend[d] = 0; end
      mbits = 0; nrise = 0;
      if (int'(cyc - cs_up_t) < min_gap) min_gap = int'(cyc - cs_up_t);
    end
    if (!cs_q && (cs_n === 1'b1)) begin
      for (int d = 0; d < N; d++) begin
        cmd = dsr[d];
        if (cmd == RDW) dpend[d] = 1;
        else if (cmd != NOPW && !cmd[W-1]) dreg[d] = cmd;
      end
      if (nfrm < 16) begin frm[nfrm] = mon; flen[nfrm] = mbits; end
      nfrm++;
      cs_up_t = cyc;
    end
    if (!sclk_q && (sclk === 1'b1) && (cs_n === 1'b0)) begin
      for (int d = 0; d < N; d++) old[d] = dsr[d];
      for (int d = 0; d < N; d++) begin
        if (d == 0) dsr[d] = {old[d][W-2:0], mosi};
        else        dsr[d] = {old[d][W-2:0], old[d-1][W-1]};
      end
      mon = {mon[FW-2:0], mosi};
      mbits++; nrise++;
      if (nrise == 2) per = int'(cyc - last_rise);
      last_rise = cyc;
    end
    sclk_q = (sclk === 1'b1);
    cs_q = (cs_n !== 1'b0);
  end

  int           nres = 0;
  int           res_idx [8];
  logic [W-1:0] res_dat [8];

  function automatic logic [FW-1:0] f_nop();
    logic [FW-1:0] f;
    for (int i = 0; i < N; i++) f[i*W +: W] = NOPW;
    return f;
  endfunction

  function automatic logic [FW-1:0] f_read(input int k);
    logic [FW-1:0] f = f_nop();
    f[k*W +: W] = RDW;
    return f;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] w = W'($urandom) & 24'h7FFFFF;
    if (w == NOPW) w = w ^ 24'h1;
    return w;
  endfunction

  task automatic drive_op(input bit w, input logic [FW-1:0] f, input logic [N-1:0] m, input logic [7:0] h);
    do_write = w; wr_frame = f; dev_mask = m; half_div = h; start = 1'b1;
    nfrm = 0; nres = 0; min_gap = 1000;
    if (w) for (int d = 0; d < N; d++) exp_reg[d] = f[d*W +: W];
  endtask

  task automatic launch(input bit w, input logic [FW-1:0] f, input logic [N-1:0] m, input logic [7:0] h);
    @(negedge clk);
    drive_op(w, f, m, h);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect();
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (nres < 8) begin res_idx[nres] = int'(rd_index); res_dat[nres] = rd_data; end
        nres++;
      end
      if (done) break;
    end
    chk(!busy, "R9 busy low at done", 128'(busy), 128'(0));
  endtask

  task automatic verify(input bit w, input logic [FW-1:0] f, input logic [N-1:0] m, input logic [7:0] h);
    int pc = $countones(m);
    int j = 0;
    int base = w ? 1 : 0;
    int eh = (h == 0) ? 1 : int'(h);
    chk(nres == pc, "R6 result count", 128'(nres), 128'(pc));
    for (int k = 0; k < N; k++) if (m[k] && j < nres && j < 8) begin
      chk(res_idx[j] == k, "R6 result order/index", 128'(res_idx[j]), 128'(k));
      chk(res_dat[j] == exp_reg[k], "R5 readback word", 128'(res_dat[j]), 128'(exp_reg[k]));
      j++;
    end
    chk(nfrm == base + 2*pc, "R6 frame count", 128'(nfrm), 128'(base + 2*pc));
    if (w && nfrm > 0) chk(frm[0] == f, "R3 write frame", 128'(frm[0] >> 8), 128'(f >> 8));
    j = 0;
    for (int k = 0; k < N; k++) if (m[k]) begin
      if (base + 2*j + 1 < nfrm && base + 2*j + 1 < 16) begin
        chk(frm[base+2*j] == f_read(k), "R4 request frame", 128'(frm[base+2*j]), 128'(f_read(k)));
        chk(frm[base+2*j+1] == f_nop(), "R5 capture frame", 128'(frm[base+2*j+1]), 128'(f_nop()));
      end
      j++;
    end
    for (int i = 0; i < nfrm && i < 16; i++)
      chk(flen[i] == FW, "R2 bits per frame", 128'(flen[i]), 128'(FW));
    if (nfrm > 0) begin
      chk(per == 2*eh, "R7 sclk period", 128'(per), 128'(2*eh));
      chk(min_gap >= GAP, "R8 cs high gap", 128'(min_gap), 128'(GAP));
    end
  endtask

  task automatic full_op(input bit w, input logic [FW-1:0] f, input logic [N-1:0] m, input logic [7:0] h);
    launch(w, f, m, h);
    collect();
    verify(w, f, m, h);
  endtask

  function automatic logic [FW-1:0] rnd_frame();
    logic [FW-1:0] f;
    for (int i = 0; i < N; i++) f[i*W +: W] = rnd_word();
    return f;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [FW-1:0] fa;
    logic [N-1:0]  ma;
    void'($urandom(32'd4242));
    for (int d = 0; d < N; d++) begin
      dsr[d] = '0; dpend[d] = 0;
      dreg[d] = 24'h010000 + 24'(d) * 24'h001111;
      exp_reg[d] = dreg[d];
    end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 bus idle in reset", {cs_n, sclk}, 2'b10);
    chk(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R1 flags low in reset",
        {busy, done, rd_valid}, 3'b000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {cs_n, busy}, 2'b10);

    // R3 R4 R5: write all slots then read all devices
    full_op(1'b1, rnd_frame(), 5'b11111, 8'd1);
    // Reads only, sparse mask, slower clock
    full_op(1'b0, '0, 5'b10100, 8'd3);
    // R7 divider of zero behaves as one
    full_op(1'b0, '0, 5'b00010, 8'd0);
    // R10 empty run
    full_op(1'b0, '0, 5'b00000, 8'd2);
    chk(nfrm == 0, "R10 no frames", 128'(nfrm), 128'(0));

    // R9 start while busy is ignored
    fa = rnd_frame();
    launch(1'b1, fa, 5'b01001, 8'd2);
    repeat (60) @(negedge clk);
    dev_mask = 5'b10000; do_write = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dev_mask = 5'b01001; do_write = 1'b1;
    collect();
    verify(1'b1, fa, 5'b01001, 8'd2);

    // R11 start in the done cycle
    launch(1'b0, '0, 5'b00011, 8'd1);
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (nres < 8) begin res_idx[nres] = int'(rd_index); res_dat[nres] = rd_data; end
        nres++;
      end
      if (done) break;
    end
    verify(1'b0, '0, 5'b00011, 8'd1);
    drive_op(1'b0, '0, 5'b11000, 8'd1);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R11 start in done cycle accepted", 128'(busy), 128'(1));
    collect();
    verify(1'b0, '0, 5'b11000, 8'd1);

    // Random runs
    for (int r = 0; r < 6; r++) begin
      ma = N'($urandom);
      full_op(1'($urandom), rnd_frame(), ma, 8'(1 + ($urandom % 3)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule